// File: doc/BRIEF.md
# Predictive Multi-Bit Code Accumulator

This block sits after the comparator of a first-order delta-sigma modulator. It turns the single comparator bit into a signed multi-bit code. The comparator bit becomes a decision of +1 or -1. A short recursion then adds twice the new decision to the previous code and takes away the decision from the sample before. The resulting code is both the converter output and the multi-bit word fed back into the loop. The recursion shapes the quantisation error with a first-order noise transfer function, (2 - z^-1)(1 - z^-1). The loop is meant to run at an oversampling ratio above 8, with inputs kept within 0 to 0.8 of full scale.

A sample is taken on each clock edge where `samp_en` is high. Data flows in one direction and the interface has no back-pressure. The block always accepts a sample. `code_valid` is a one-cycle strobe with no ready signal, so downstream logic must capture `code` in the cycle the strobe is high. The state is the code register and the stored previous decision. The datapath is one adder with a doubling stage in front of it, followed by a clamp.

Top module: `predq_accum`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `code` to 0, clears the stored previous decision to 0, and drives `code_valid` and `code_ovf` low. As a result, the first sample after reset moves the code by exactly +2 or -2.
- R2: A comparator bit of 1 counts as decision +1, and a comparator bit of 0 counts as decision -1.
- R3: On a sample edge, the new code is the old code plus twice the current decision minus the stored previous decision. The current decision then becomes the stored previous decision.
- R4: When the sum leaves the signed range, it is clamped to +7 (above) or -8 (below). In the cycle after a clamped update, `code_ovf` is 1. In every other cycle it is 0.
- R5: On an edge where `samp_en` is low, neither `code` nor the stored previous decision changes, whatever `cmp_bit` is.
- R6: `code_valid` is 1 in the cycle after a sample edge and 0 in the cycle after an edge with no sample.
- R7: Apart from the first sample after reset and clamped updates, each update moves the code by exactly 1 or 3 LSBs.
- R8: `code` is a 4-bit two's-complement value. For example, -8 is 4'b1000 and +7 is 4'b0111.
- R9: A sample with a comparator bit of 1 never lowers the code, and a sample with a comparator bit of 0 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_en | input | 1 | Take a comparator sample at this edge |
| cmp_bit | input | 1 | Comparator decision, 1 = positive |
| code | output | 4 | Signed output and feedback code |
| code_valid | output | 1 | One-cycle strobe after each update |
| code_ovf | output | 1 | One-cycle flag after a clamped update |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe timing against `samp_en`;
- the hold of the code while no sample is taken;
- the allowed step sizes;
- the direction of each step against the comparator bit;
- the overflow flag only appearing with the code at a limit.

Other behaviour can only be shown by the bench's sweeps:
- the exact arithmetic of the recursion;
- the stored previous decision surviving idle cycles;
- the zero previous decision after reset.

The bench exercises these by running every comparator sequence up to eight samples long, with and without idle gaps.

// File: rtl/predq_pkg.sv
package predq_pkg;
  typedef logic signed [1:0] dec_t;
  localparam dec_t DEC_POS  = 2'sb01;
  localparam dec_t DEC_NEG  = 2'sb11;
  localparam dec_t DEC_NONE = 2'sb00;
endpackage

// File: rtl/predq_decision.sv
module predq_decision
  import predq_pkg::*;
(
  input  logic cmp_bit,
  output dec_t q_now
);
  always_comb q_now = cmp_bit ? DEC_POS : DEC_NEG;
endmodule

// File: rtl/predq_sum.sv
module predq_sum
  import predq_pkg::*;
#(
  parameter int W  = 4,
  parameter int SW = W + 2
) (
  input  logic signed [W-1:0]  prev_code,
  input  dec_t                 q_now,
  input  dec_t                 q_old,
  output logic signed [SW-1:0] raw_sum
);
  logic signed [SW-1:0] code_x, now_x, now_x2, old_x;

  always_comb begin
    code_x  = {{(SW-W){prev_code[W-1]}}, prev_code};
    now_x   = {{(SW-2){q_now[1]}}, q_now};
    now_x2  = {now_x[SW-2:0], 1'b0};
    old_x   = {{(SW-2){q_old[1]}}, q_old};
    raw_sum = code_x + now_x2 - old_x;
  end
endmodule

// File: rtl/predq_clamp.sv
module predq_clamp #(
  parameter int W  = 4,
  parameter int SW = W + 2
) (
  input  logic signed [SW-1:0] raw_sum,
  output logic signed [W-1:0]  code_sat,
  output logic                 clamped
);
  localparam int HI_I = (2 ** (W - 1)) - 1;
  localparam int LO_I = -(2 ** (W - 1));
  localparam logic signed [SW-1:0] HI = SW'(HI_I);
  localparam logic signed [SW-1:0] LO = SW'(LO_I);

  always_comb begin
    clamped = 1'b0;
    if (raw_sum > HI) begin
      code_sat = HI[W-1:0];
      clamped  = 1'b1;
    end else if (raw_sum < LO) begin
      code_sat = LO[W-1:0];
      clamped  = 1'b1;
    end else begin
      code_sat = raw_sum[W-1:0];
    end
  end
endmodule

// File: rtl/predq_accum.sv
module predq_accum
  import predq_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         samp_en,
  input  logic         cmp_bit,
  output logic [W-1:0] code,
  output logic         code_valid,
  output logic         code_ovf
);
  localparam int SW = W + 2;

  dec_t                 q_now, q_old;
  logic signed [W-1:0]  code_q, code_nx;
  logic signed [SW-1:0] raw_sum;
  logic                 clamped;

  predq_decision u_dec (.cmp_bit(cmp_bit), .q_now(q_now));

  predq_sum #(.W(W), .SW(SW)) u_sum (
    .prev_code(code_q), .q_now(q_now), .q_old(q_old), .raw_sum(raw_sum)
  );

  predq_clamp #(.W(W), .SW(SW)) u_clamp (
    .raw_sum(raw_sum), .code_sat(code_nx), .clamped(clamped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q     <= '0;
      q_old      <= DEC_NONE;
      code_valid <= 1'b0;
      code_ovf   <= 1'b0;
    end else begin
      code_valid <= samp_en;
      code_ovf   <= samp_en & clamped;
      if (samp_en) begin
        code_q <= code_nx;
        q_old  <= q_now;
      end
    end
  end

  assign code = code_q;
endmodule

// File: rtl/predq_accum_chk.sv
module predq_accum_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         samp_en,
  input logic         cmp_bit,
  input logic [W-1:0] code,
  input logic         code_valid,
  input logic         code_ovf
);
  localparam logic [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] BOT = {1'b1, {(W-1){1'b0}}};

  logic signed [W+1:0] cur_x, prev_x, diff;
  logic [W-1:0] prev_code;

  always_ff @(posedge clk) prev_code <= code;

  always_comb begin
    cur_x  = {{2{code[W-1]}}, code};
    prev_x = {{2{prev_code[W-1]}}, prev_code};
    diff   = cur_x - prev_x;
  end

  p_valid_after_sample_r6: assert property (@(posedge clk) disable iff (rst)
    samp_en |=> code_valid);
  p_no_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> !code_valid);
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> $stable(code));
  p_ovf_at_limit_r4: assert property (@(posedge clk) disable iff (rst)
    code_ovf |-> (code == TOP || code == BOT));
  p_step_size_r7: assert property (@(posedge clk) disable iff (rst)
    (samp_en && !$past(rst)) |=> (code_ovf || diff == 1 || diff == -1 || diff == 2 ||
                                  diff == -2 || diff == 3 || diff == -3));
  p_up_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    (samp_en && cmp_bit) |=> diff >= 0);
  p_down_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    (samp_en && !cmp_bit) |=> diff <= 0);
endmodule

bind predq_accum predq_accum_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .samp_en(samp_en), .cmp_bit(cmp_bit),
  .code(code), .code_valid(code_valid), .code_ovf(code_ovf)
);

// File: tb/predq_accum_test.sv
module predq_accum_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_en = 1'b0;
  logic cmp_bit = 1'b0;
  logic [W-1:0] code;
  logic code_valid, code_ovf;

  int checks = 0;
  int errors = 0;
  int m_code = 0;
  int m_qold = 0;
  bit first = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  predq_accum #(.W(W)) uut (
    .clk(clk), .rst(rst), .samp_en(samp_en), .cmp_bit(cmp_bit),
    .code(code), .code_valid(code_valid), .code_ovf(code_ovf)
  );

  function automatic int sval(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; samp_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_code = 0; m_qold = 0; first = 1'b1;
    chk("R1 code", sval(code), 0);
    chk("R1 valid", int'(code_valid), 0);
    chk("R1 ovf", int'(code_ovf), 0);
  endtask

  task automatic step(input bit en, input bit b);
    int q, s, prev;
    bit ov;
    samp_en = en; cmp_bit = b;
    prev = m_code; ov = 1'b0;
    if (en) begin
      q = b ? 1 : -1;
      s = m_code + 2 * q - m_qold;
      if (s > 7) begin s = 7; ov = 1'b1; end
      if (s < -8) begin s = -8; ov = 1'b1; end
      m_code = s; m_qold = q;
    end
    @(negedge clk);
    if (en) chk("R3 code", sval(code), m_code);
    else    chk("R5 held code", sval(code), m_code);
    chk("R4 ovf", int'(code_ovf), int'(ov));
    chk("R6 valid", int'(code_valid), int'(en));
    if (en && !ov && !first) begin
      int d = (m_code > prev) ? m_code - prev : prev - m_code;
      chk("R7 step is 1 or 3", int'(d == 1 || d == 3), 1);
    end
    if (en) first = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    do_reset();
    // R1/R2: first sample from reset is +2 for bit 1, -2 for bit 0
    step(1'b1, 1'b1);
    chk("R2 first high", sval(code), 2);
    do_reset();
    step(1'b1, 1'b0);
    chk("R2 first low", sval(code), -2);
    // R4/R8: saturate low, check encoding 4'b1000
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    chk("R8 min encoding", int'(code), 8);
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    chk("R8 max encoding", int'(code), 7);
    // R5: idle cycles with toggling comparator leave state untouched
    for (int i = 0; i < 4; i++) step(1'b0, i[0]);
    step(1'b1, 1'b0);
    chk("R5 prev decision kept", sval(code), 4);
    // exhaustive sweep of sequences up to 8 samples, with and without gaps
    for (int len = 1; len <= 8; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        for (int gap = 0; gap < 2; gap++) begin
          do_reset();
          for (int k = 0; k < len; k++) begin
            step(1'b1, pat[k]);
            if (gap == 1) step(1'b0, ~pat[k]);
          end
        end
      end
    end
    // R1: reset in mid-run clears state
    step(1'b1, 1'b1);
    do_reset();
    step(1'b1, 1'b1);
    chk("R1 reset mid-run", sval(code), 2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule